// File: doc/BRIEF.md
# Base and Bound Address Relocation Unit

This block sits between a processor core and its memory path and turns every virtual address the core issues into a physical one under a single relocation window. Two privileged registers describe the window. The relocation offset is added to the virtual address, and the window size sets the limit that the virtual address must stay below. A load, a store and an instruction fetch all pass through the same check. A legal access yields a physical address. An illegal one raises a fault pulse toward the kernel and issues no memory access.

The adder and the limit comparator see the same operands in the same cycle, so relocation adds no serial step to the check. The kernel reprograms the window through a configuration port, for example to move a process or to switch contexts. That port honours writes only while the mode input says kernel. A write attempted in user mode changes nothing and raises a privilege-denial pulse. On every fault the offending virtual address and access kind are captured for the handler.

Top module: `bbr_unit`

## Requirements
- R1: After reset both the relocation offset and the window size are 0, all response pulses are low, and the first request of any kind faults.
- R2: A legal access returns a physical address equal to the virtual address plus the relocation offset, taken modulo 2^PA_W.
- R3: An access is legal exactly when its virtual address, read as unsigned, is below the window size. An address equal to the window size faults, and one below it by one is legal.
- R4: Each cycle with `req_valid` high gives exactly one of `acc_ok` or `acc_fault` one cycle later. Neither pulse appears otherwise, and the two are never high together.
- R5: The check is the same for every access kind, coded load=0, store=1, fetch=2. `acc_kind` echoes the kind of the request being answered.
- R6: A kernel-mode write (`cfg_we` with `priv_kernel`=1) loads `cfg_wdata` into the offset when `cfg_sel`=0, or into the window size (low VA_W bits) when `cfg_sel`=1. A request in the same cycle as the write still uses the old values. Later requests use the new ones.
- R7: A configuration write with `priv_kernel`=0 leaves both registers unchanged, and `cfg_deny` pulses high for one cycle in the next cycle.
- R8: A faulting access drives `acc_paddr` to 0 with `acc_ok` low, so no memory access is issued for it.
- R9: On a fault, `flt_vaddr` and `flt_kind` capture the faulting request's address and kind. They hold their value across legal accesses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = relocation offset, 1 = window size |
| cfg_wdata | input | PA_W | Configuration write data |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| acc_ok | output | 1 | Legal translation pulse |
| acc_fault | output | 1 | Bound-fault trap pulse |
| acc_paddr | output | PA_W | Physical address (0 on fault) |
| acc_kind | output | 2 | Kind of the answered request |
| cfg_deny | output | 1 | Privilege-denial trap pulse |
| flt_vaddr | output | VA_W | Captured faulting virtual address |
| flt_kind | output | 2 | Captured faulting access kind |

## Verification
The assertions assume that `req_kind` never carries the reserved code 3. They also assume that every input is a known value at each rising edge after reset, because the one-pulse-per-request and the fault-capture properties reason over plain sampled values. The bench drives only the three defined kinds and changes its inputs only on falling edges. It holds all strobes low during reset, so each property sees clean, settled stimulus from its first enabled cycle.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  localparam logic SEL_OFFSET = 1'b0;
  localparam logic SEL_WINDOW = 1'b1;

endpackage

// File: rtl/bbr_regs.sv
module bbr_regs
  import bbr_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_kernel,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic [PA_W-1:0] offset_q,
  output logic [VA_W-1:0] window_q,
  output logic            deny_q
);

  logic            wr_ok;
  logic            offset_en;
  logic            window_en;
  logic [PA_W-1:0] offset_d;
  logic [VA_W-1:0] window_d;
  logic            deny_d;

  always_comb begin
    wr_ok     = cfg_we & priv_kernel;
    offset_en = wr_ok & (cfg_sel == SEL_OFFSET);
    window_en = wr_ok & (cfg_sel == SEL_WINDOW);
    offset_d  = cfg_wdata;
    window_d  = cfg_wdata[VA_W-1:0];
    deny_d    = cfg_we & ~priv_kernel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else if (offset_en) begin
      offset_q <= offset_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= '0;
    end else if (window_en) begin
      window_q <= window_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_q <= 1'b0;
    end else begin
      deny_q <= deny_d;
    end
  end

  // R7
  user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_kernel) |=> ($stable(offset_q) && $stable(window_q) && deny_q));

  // R7
  deny_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny_q |-> $past(cfg_we && !priv_kernel));

endmodule

// File: rtl/bbr_xlate.sv
module bbr_xlate #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [PA_W-1:0] offset,
  input  logic [VA_W-1:0] window,
  output logic [PA_W-1:0] paddr,
  output logic            in_range
);

  localparam int PAD_W = PA_W - VA_W;

  logic [PA_W-1:0] va_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb va_ext = {{PAD_W{1'b0}}, vaddr};
    end else begin : g_same
      always_comb va_ext = vaddr;
    end
  endgenerate

  // Adder and comparator share operands and run side by side.
  always_comb begin
    paddr    = va_ext + offset;
    in_range = (vaddr < window);
  end

endmodule

// File: rtl/bbr_resp.sv
module bbr_resp #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic [PA_W-1:0] xl_paddr,
  input  logic            xl_in_range,
  output logic            ok_q,
  output logic            fault_q,
  output logic [PA_W-1:0] paddr_q,
  output logic [1:0]      kind_q,
  output logic [VA_W-1:0] flt_vaddr_q,
  output logic [1:0]      flt_kind_q
);

  logic            ok_d;
  logic            fault_d;
  logic [PA_W-1:0] paddr_d;
  logic [1:0]      kind_d;
  logic            kind_en;

  always_comb begin
    ok_d    = req_valid & xl_in_range;
    fault_d = req_valid & ~xl_in_range;
    paddr_d = ok_d ? xl_paddr : '0;
    kind_en = req_valid;
    kind_d  = req_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      ok_q    <= ok_d;
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
    end else if (kind_en) begin
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_vaddr_q <= '0;
      flt_kind_q  <= '0;
    end else if (fault_d) begin
      flt_vaddr_q <= req_vaddr;
      flt_kind_q  <= req_kind;
    end
  end

  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  // R4
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && fault_q));

  // R4
  pulse_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> ((ok_q || fault_q) == $past(req_valid)));

  // R8
  fault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_q |-> (paddr_q == '0));

  // R9
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !fault_q) |-> ($stable(flt_vaddr_q) && $stable(flt_kind_q)));

  // R5
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_kind != 2'd3));

endmodule

// File: rtl/bbr_unit.sv
module bbr_unit #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_kernel,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  output logic            acc_ok,
  output logic            acc_fault,
  output logic [PA_W-1:0] acc_paddr,
  output logic [1:0]      acc_kind,
  output logic            cfg_deny,
  output logic [VA_W-1:0] flt_vaddr,
  output logic [1:0]      flt_kind
);

  logic [PA_W-1:0] offset_q;
  logic [VA_W-1:0] window_q;
  logic [PA_W-1:0] xl_paddr;
  logic            xl_in_range;

  bbr_regs #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_kernel (priv_kernel),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .offset_q    (offset_q),
    .window_q    (window_q),
    .deny_q      (cfg_deny)
  );

  bbr_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .vaddr    (req_vaddr),
    .offset   (offset_q),
    .window   (window_q),
    .paddr    (xl_paddr),
    .in_range (xl_in_range)
  );

  bbr_resp #(.VA_W(VA_W), .PA_W(PA_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_kind    (req_kind),
    .xl_paddr    (xl_paddr),
    .xl_in_range (xl_in_range),
    .ok_q        (acc_ok),
    .fault_q     (acc_fault),
    .paddr_q     (acc_paddr),
    .kind_q      (acc_kind),
    .flt_vaddr_q (flt_vaddr),
    .flt_kind_q  (flt_kind)
  );

  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  // R3
  legal_below_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && acc_ok) |-> ($past(req_vaddr) < $past(window_q)));

  // R3
  fault_at_or_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && acc_fault) |-> ($past(req_vaddr) >= $past(window_q)));

  // R9
  capture_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && acc_fault) |-> (flt_vaddr == $past(req_vaddr) && flt_kind == $past(req_kind)));

endmodule

// File: tb/tb_bbr_unit.sv
`timescale 1ns/1ps
module tb_bbr_unit;

  localparam int VA_W = 32;
  localparam int PA_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            priv_kernel;
  logic            cfg_we;
  logic            cfg_sel;
  logic [PA_W-1:0] cfg_wdata;
  logic            req_valid;
  logic [VA_W-1:0] req_vaddr;
  logic [1:0]      req_kind;
  logic            acc_ok;
  logic            acc_fault;
  logic [PA_W-1:0] acc_paddr;
  logic [1:0]      acc_kind;
  logic            cfg_deny;
  logic [VA_W-1:0] flt_vaddr;
  logic [1:0]      flt_kind;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bbr_unit #(.VA_W(VA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .acc_ok(acc_ok), .acc_fault(acc_fault), .acc_paddr(acc_paddr),
    .acc_kind(acc_kind), .cfg_deny(cfg_deny),
    .flt_vaddr(flt_vaddr), .flt_kind(flt_kind)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drive at a falling edge; the response is sampled at the next falling edge.
  task automatic cfg_write(input logic kern, input logic sel, input logic [PA_W-1:0] d);
    priv_kernel = kern; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; priv_kernel = 1'b1;
  endtask

  task automatic access(input logic [VA_W-1:0] va, input logic [1:0] k,
                        input logic exp_ok, input logic [PA_W-1:0] exp_pa, input string req);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " ok"}, acc_ok, exp_ok);
    check({req, " fault"}, acc_fault, !exp_ok);
    check({req, " paddr"}, acc_paddr, exp_ok ? exp_pa : '0);
    check({req, " kind"}, acc_kind, k);
  endtask

  task automatic t_reset();
    check("R1 ok idle", acc_ok, 0);
    check("R1 fault idle", acc_fault, 0);
    check("R1 deny idle", cfg_deny, 0);
    access(32'h0, 2'd2, 1'b0, '0, "R1 first fetch faults");
    check("R1 fault vaddr", flt_vaddr, 32'h0);
  endtask

  task automatic t_basic();
    cfg_write(1'b1, 1'b0, 32'h0000_1000);
    cfg_write(1'b1, 1'b1, 32'h0000_0200);
    access(32'h10, 2'd0, 1'b1, 32'h1010, "R2 load relocated");
    access(32'h1FF, 2'd1, 1'b1, 32'h11FF, "R3 last legal store");
    access(32'h200, 2'd1, 1'b0, '0, "R3 R8 store at window");
    check("R9 flt_vaddr", flt_vaddr, 32'h200);
    check("R9 flt_kind", flt_kind, 2'd1);
    access(32'h100, 2'd2, 1'b1, 32'h1100, "R5 fetch legal");
    access(32'hFFFF_FFFF, 2'd0, 1'b0, '0, "R3 R5 load far above");
    check("R9 flt_kind load", flt_kind, 2'd0);
    access(32'h4, 2'd1, 1'b1, 32'h1004, "R5 store legal");
    check("R9 hold after legal", flt_vaddr, 32'hFFFF_FFFF);
  endtask

  task automatic t_wrap();
    cfg_write(1'b1, 1'b0, 32'hFFFF_F000);
    cfg_write(1'b1, 1'b1, 32'h0000_2000);
    access(32'h1800, 2'd0, 1'b1, 32'h0000_0800, "R2 wrap modulo");
  endtask

  task automatic t_user_write();
    cfg_write(1'b0, 1'b1, 32'h0000_FFFF);
    check("R7 deny pulse", cfg_deny, 1);
    @(negedge clk);
    check("R7 deny one cycle", cfg_deny, 0);
    access(32'h2000, 2'd0, 1'b0, '0, "R7 window unchanged");
    cfg_write(1'b0, 1'b0, 32'h0000_0000);
    access(32'h1FFF, 2'd2, 1'b1, 32'h0000_0FFF, "R7 offset unchanged");
    check("R7 no deny for kernel", cfg_deny, 0);
  endtask

  task automatic t_same_cycle();
    // Offset currently FFFF_F000; write 5000 alongside a request.
    priv_kernel = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h5000;
    req_valid = 1'b1; req_vaddr = 32'h4; req_kind = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R6 same-cycle old offset", acc_paddr, 32'hFFFF_F004);
    access(32'h4, 2'd0, 1'b1, 32'h5004, "R6 new offset later");
  endtask

  task automatic t_stream();
    req_valid = 1'b1; req_vaddr = 32'h10; req_kind = 2'd0;
    @(negedge clk);
    check("R4 stream 1 ok", acc_ok, 1);
    check("R4 stream 1 pa", acc_paddr, 32'h5010);
    req_vaddr = 32'h3000; req_kind = 2'd1;
    @(negedge clk);
    check("R4 stream 2 fault", acc_fault, 1);
    check("R4 stream 2 ok low", acc_ok, 0);
    req_vaddr = 32'h20; req_kind = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 stream 3 ok", acc_ok, 1);
    check("R4 stream 3 kind", acc_kind, 2'd2);
    check("R9 stream fault kept", flt_vaddr, 32'h3000);
    @(negedge clk);
    check("R4 idle no ok", acc_ok, 0);
    check("R4 idle no fault", acc_fault, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; priv_kernel = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_user_write();
    t_same_cycle();
    t_stream();
    finish_run();
  end

endmodule